// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is a single pulse-width-modulation timer channel. Software loads a period value and a compare value into two shadow buffers. Neither buffer drives the output directly. Their contents move into the working down counter and the working compare register only in two cases: a manual update strobe, or the counter finishing a period at zero while automatic reload is on. Because of this, a new period and duty setting never tears a cycle that is already running.

The counter moves one step toward zero on each cycle in which the tick enable is high and the channel is running. The output is active while the counter is above the working compare value. An all-ones compare value gives a constantly active output. An invert control flips the pin. A one-cycle end-of-period pulse marks the tick that consumes the zero count.

To start the channel, first pulse the update control with run low, then raise run together with automatic reload. To stop it, clear automatic reload: the running period completes, and the counter then rests at zero.

Top module: `dbpwm_channel`

## Requirements
- R1: After reset the shadow buffers, counter and working compare are zero, `period_end` is low, and `pwm_out` equals `ctl_inv`.
- R2: A write to either shadow buffer leaves the counter, the working compare and `pwm_out` unchanged until the next update or reload.
- R3: With `ctl_load` high at a clock edge, the counter takes the count buffer and the working compare takes the compare buffer. While `ctl_run` is low the counter holds and `pwm_out` equals `ctl_inv`.
- R4: While running, the counter decreases by one on each edge with `tick` high, and holds on edges with `tick` low.
- R5: The un-inverted output is high exactly while the counter exceeds the working compare. A count buffer of N with compare C gives N+1 ticks per period, of which N−C are high.
- R6: A working compare of all ones (16'hFFFF at the default width) keeps the un-inverted output high for every counter value.
- R7: On a tick at counter zero with `ctl_rearm` high, both buffers are copied in, so buffer values written mid-period take effect at the next period.
- R8: With `ctl_rearm` low, the period in progress still completes. The counter then stays at zero, the output stays at its low level, and no further end-of-period pulse appears.
- R9: `period_end` is high for one cycle after each tick that consumes counter zero while running. It is not repeated once the channel has stopped at zero.
- R10: `ctl_inv` high inverts `pwm_out`, both when running and when idle.
- R11: `ctl_load` takes priority over a tick in the same cycle. The counter loads and does not decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| cnt_buf_we | input | 1 | Write strobe for the count buffer |
| cnt_buf_wdata | input | CNT_W | Period length in ticks minus one |
| cmp_buf_we | input | 1 | Write strobe for the compare buffer |
| cmp_buf_wdata | input | CNT_W | Compare value; all ones means full duty |
| ctl_run | input | 1 | Channel running |
| ctl_load | input | 1 | Manual update: copy buffers to working registers |
| ctl_inv | input | 1 | Invert the output |
| ctl_rearm | input | 1 | Reload automatically at the end of each period |
| pwm_out | output | 1 | PWM pin |
| period_end | output | 1 | One-cycle end-of-period pulse |

## Verification
The hardest case to reach from the ports is a buffer write that lands in the middle of a running period. The old working values must finish that period, and the new ones must appear exactly at the wrap. The stimulus rewrites both buffers while the counter is partway down, then keeps ticking through the boundary. It also drives a graceful stop, with reload cleared mid-period, and a full-duty load that arrives together with a tick. Expected pin and pulse values come from a model of the requirements kept in the driver and are queued for the monitor.

// File: rtl/dbpwm_channel.sv
module dbpwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_buf_we,
  input  logic [CNT_W-1:0] cnt_buf_wdata,
  input  logic             cmp_buf_we,
  input  logic [CNT_W-1:0] cmp_buf_wdata,
  input  logic             ctl_run,
  input  logic             ctl_load,
  input  logic             ctl_inv,
  input  logic             ctl_rearm,
  output logic             pwm_out,
  output logic             period_end
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_buf, cmp_buf, cnt, cmp_act;
  logic             done;

  wire step    = ctl_run & tick & ~ctl_load;
  wire at_zero = (cnt == '0);
  wire wrap    = step & at_zero & ctl_rearm;
  wire raw     = (cmp_act == ALL_ONES) | (cnt > cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_buf    <= '0;
      cmp_buf    <= '0;
      cnt        <= '0;
      cmp_act    <= '0;
      done       <= 1'b0;
      period_end <= 1'b0;
    end else begin
      if (cnt_buf_we) cnt_buf <= cnt_buf_wdata;
      if (cmp_buf_we) cmp_buf <= cmp_buf_wdata;
      if (ctl_load || wrap) begin
        cnt     <= cnt_buf;
        cmp_act <= cmp_buf;
        done    <= 1'b0;
      end else if (step && at_zero) begin
        done <= 1'b1;
      end else if (step) begin
        cnt <= cnt - 1'b1;
      end
      period_end <= step & at_zero & ~done;
    end
  end

  assign pwm_out = ctl_run ? (raw ^ ctl_inv) : ctl_inv;

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_load |=> (cnt == $past(cnt_buf)) && (cmp_act == $past(cmp_buf)));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_run && !ctl_load) |=> $stable(cnt));
  p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && !tick && !ctl_load) |=> $stable(cnt));
  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && tick && !ctl_load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_run && tick && !ctl_load && cnt == '0 && ctl_rearm) |=> cnt == $past(cnt_buf));
  p_stop_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !ctl_rearm && !ctl_load) |=> cnt == '0);
  p_pulse_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_end) |-> $past(cnt) == '0);
endmodule

// File: tb/tb_dbpwm_channel.sv
module tb_dbpwm_channel;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic tick = 0, cnt_buf_we = 0, cmp_buf_we = 0;
  logic [W-1:0] cnt_buf_wdata = '0, cmp_buf_wdata = '0;
  logic ctl_run = 0, ctl_load = 0, ctl_inv = 0, ctl_rearm = 0;
  logic pwm_out, period_end;

  dbpwm_channel #(.CNT_W(W)) dut (.*);

  always #5 clk = ~clk;

  int applied = 0, errors = 0, cycles = 0;
  logic  q_out[$];
  logic  q_pe[$];
  string q_req[$];

  logic [W-1:0] m_cbuf = '0, m_pbuf = '0, m_cnt = '0, m_cmp = '0;
  logic m_done = 0;

  task automatic drive(input bit wc, input logic [W-1:0] cd, input bit wp, input logic [W-1:0] pd,
                       input bit ld, input bit run, input bit inv, input bit rearm, input bit tk,
                       input string req);
    logic pe, raw, stp;
    @(negedge clk);
    cnt_buf_we = wc; cnt_buf_wdata = cd; cmp_buf_we = wp; cmp_buf_wdata = pd;
    ctl_load = ld; ctl_run = run; ctl_inv = inv; ctl_rearm = rearm; tick = tk;
    stp = run && tk && !ld;
    pe = stp && (m_cnt == 0) && !m_done;
    if (ld || (stp && m_cnt == 0 && rearm)) begin
      m_cnt = m_cbuf; m_cmp = m_pbuf; m_done = 0;
    end else if (stp && m_cnt == 0) m_done = 1;
    else if (stp) m_cnt = m_cnt - 1;
    if (wc) m_cbuf = cd;
    if (wp) m_pbuf = pd;
    raw = (m_cmp == '1) || (m_cnt > m_cmp);
    q_out.push_back(run ? (raw ^ inv) : inv);
    q_pe.push_back(pe);
    q_req.push_back(req);
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      if (q_out.size() > 0) begin
        logic eo, ep; string r;
        eo = q_out.pop_front(); ep = q_pe.pop_front(); r = q_req.pop_front();
        applied++;
        if (pwm_out !== eo || period_end !== ep) begin
          errors++;
          $display("FAIL %s: pwm_out=%b period_end=%b expected pwm_out=%b period_end=%b",
                   r, pwm_out, period_end, eo, ep);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    applied++;
    if (pwm_out !== 1'b0 || period_end !== 1'b0) begin
      errors++;
      $display("FAIL R1: pwm_out=%b period_end=%b expected 0 0", pwm_out, period_end);
    end
    @(negedge clk); rst_n = 1;
    // R2: buffer writes while idle change nothing
    drive(1, 16'd4, 1, 16'd1, 0, 0, 0, 0, 1, "R2");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R2");
    // R3: manual update while stopped
    drive(0, 0, 0, 0, 1, 0, 0, 0, 0, "R3");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R3");
    // R4 R5 R7 R9: running with reload, every cycle a tick
    for (int i = 0; i < 12; i++) drive(0, 0, 0, 0, 0, 1, 0, 1, 1, "R5");
    // R4: sparse ticks
    for (int i = 0; i < 8; i++) drive(0, 0, 0, 0, 0, 1, 0, 1, i[0], "R4");
    // R7 R2: mid-period rewrite, effective at wrap
    drive(1, 16'd2, 1, 16'd0, 0, 1, 0, 1, 1, "R2");
    for (int i = 0; i < 12; i++) drive(0, 0, 0, 0, 0, 1, 0, 1, 1, "R7");
    // R10: invert while running
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 0, 0, 1, 1, 1, 1, "R10");
    // R11 R6: full duty, load together with tick
    drive(1, 16'd3, 1, 16'hFFFF, 0, 1, 0, 1, 0, "R2");
    drive(0, 0, 0, 0, 1, 1, 0, 1, 1, "R11");
    for (int i = 0; i < 9; i++) drive(0, 0, 0, 0, 0, 1, 0, 1, 1, "R6");
    // R8: clear reload mid-period, period finishes then rests
    drive(1, 16'd5, 1, 16'd2, 1, 1, 0, 1, 0, "R11");
    drive(0, 0, 0, 0, 0, 1, 0, 1, 1, "R8");
    for (int i = 0; i < 10; i++) drive(0, 0, 0, 0, 0, 1, 0, 0, 1, "R8");
    // R9: no repeated pulse at rest, R10 idle invert
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 0, 1, 0, 0, 1, "R9");
    drive(0, 0, 0, 0, 0, 0, 1, 0, 1, "R10");
    drive(0, 0, 0, 0, 1, 0, 1, 0, 1, "R3");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R3");
    repeat (3) @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule